// File: doc/BRIEF.md
# Preemptive Round-Robin Task Dispatcher

This block hands task identifiers to a small array of cores once per scheduling period. It holds two first-in first-out queues of task numbers. One holds tasks that are ready for a fresh job, and the other holds tasks whose job was interrupted. A free-running counter raises a tick every `TICK_PERIOD` cycles. Each tick starts a pass that visits every core twice, one core per cycle. The first sweep interrupts every occupied core. The second sweep fills every free core.

When the second sweep fills a core, interrupted work always wins over fresh work. A core resumes the oldest interrupted task that was already queued when the tick fired. A fresh job is taken from the ready queue only when no such task is left. A task interrupted during the current pass waits for a later tick. Outside the block, new tasks enter through a release port. Cores report completion through a done port, and the finished task goes back to the ready queue.

Top module: `preempt_rr_dispatcher`

## Requirements
- R1: `tick_o` is a one-cycle pulse. The first pulse is visible `TICK_PERIOD`+1 cycles after reset is released, and later pulses follow every `TICK_PERIOD` cycles.
- R2: After a tick, core k (k = 0..NUM_CORES-1) is visited for preemption in the k-th cycle of the pass. It is visited for assignment NUM_CORES cycles later. A command for the visit appears on the outputs one cycle after the visit, and at most one command is issued per cycle.
- R3: Command encoding on `cmd_op_o` is 1 = start a new job, 2 = resume an interrupted job, 3 = preempt (yield). When `cmd_valid_o` is low, op, core and task all read 0.
- R4: A core that is occupied at its preemption visit receives op 3 carrying its task ID. It becomes free, and that ID joins the tail of the preempted queue.
- R5: A free core at its assignment visit resumes the head of the preempted queue while interrupted tasks queued before the tick remain. It becomes occupied with that ID.
- R6: A start (op 1) pops the head of the ready queue. This happens only when no preempted task that was eligible at the tick remains and the ready queue was non-empty at the start of the cycle.
- R7: A task preempted during a pass is not resumed within that same pass.
- R8: `done_valid_i` for an occupied core returns its task ID to the tail of the ready queue and frees the core. `done_valid_i` for a free core has no effect.
- R9: A done event for a core in the same cycle as that core's preemption visit suppresses the preempt command. The task goes to the ready queue instead.
- R10: `rel_valid_i` appends `rel_task_i` to the ready queue. When a done event and a release fall in the same cycle, the done task is queued first.
- R11: Each queue holds NUM_TASKS IDs. A pop in the same cycle does not make room. A push into a full queue is dropped and sets `err_o`, which stays high until reset.
- R12: After reset both queues are empty, all cores are free, and no command, tick or error is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rel_valid_i | input | 1 | Release a task into the ready queue |
| rel_task_i | input | $clog2(NUM_TASKS) | ID of the released task |
| done_valid_i | input | 1 | A core finished its current job |
| done_core_i | input | $clog2(NUM_CORES) | Index of the core reporting completion |
| tick_o | output | 1 | Scheduling tick pulse |
| cmd_valid_o | output | 1 | A command is issued this cycle |
| cmd_op_o | output | 2 | 1 start, 2 resume, 3 preempt |
| cmd_core_o | output | $clog2(NUM_CORES) | Target core of the command |
| cmd_task_o | output | $clog2(NUM_TASKS) | Task ID carried by the command |
| core_busy_o | output | NUM_CORES | Per-core occupied flags |
| err_o | output | 1 | Sticky queue-overflow flag |

## Verification
The checker watches several properties on every cycle. Commands appear only inside the 2·NUM_CORES-cycle window after a tick, and each visits the core matching its slot in the sweep. A preempt always frees an occupied core, and a start or resume always occupies a free one. A done event frees its core, the tick is a single-cycle pulse, and the error flag stays set. Other properties depend on which IDs land where, and only the bench's cycle-by-cycle reference queues can show them. These include first-come ordering within each queue and priority of interrupted over fresh work. They also include holding back tasks preempted in the current pass and the done-before-release order. The bench also drives the done-at-preemption collision and an overflow through repeated releases.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_START   = 2'd1,
        OP_RESUME  = 2'd2,
        OP_PREEMPT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PREEMPT = 2'd1,
        PH_ASSIGN  = 2'd2
    } phase_e;

endpackage

// File: rtl/rrd_tick_gen.sv
module rrd_tick_gen #(
    parameter int PERIOD = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rrd_id_fifo.sv
module rrd_id_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         push0_i,
    input  logic [W-1:0]                 data0_i,
    input  logic                         push1_i,
    input  logic [W-1:0]                 data1_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         drop_o
);
    localparam int PW  = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int QCW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [QCW-1:0]          cnt;
    } fifo_t;

    fifo_t st_q, st_d;

    function automatic logic [PW-1:0] slot_at(input logic [PW-1:0] base, input int off);
        int s;
        s = (int'(base) + off) % DEPTH;
        return PW'(s);
    endfunction

    always_comb begin
        int fill;
        int popped;
        st_d   = st_q;
        drop_o = 1'b0;
        fill   = int'(st_q.cnt);
        popped = 0;
        // earlier port first; a pop in this cycle never frees a slot
        if (push0_i) begin
            if (fill < DEPTH) begin
                st_d.mem[slot_at(st_q.rd, fill)] = data0_i;
                fill = fill + 1;
            end else begin
                drop_o = 1'b1;
            end
        end
        if (push1_i) begin
            if (fill < DEPTH) begin
                st_d.mem[slot_at(st_q.rd, fill)] = data1_i;
                fill = fill + 1;
            end else begin
                drop_o = 1'b1;
            end
        end
        if (pop_i && (st_q.cnt != '0)) begin
            st_d.rd = slot_at(st_q.rd, 1);
            popped  = 1;
        end
        st_d.cnt = QCW'(fill - popped);
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign count_o = st_q.cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/preempt_rr_dispatcher.sv
module preempt_rr_dispatcher
    import rrd_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int NUM_TASKS   = 8,
    parameter int TICK_PERIOD = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          rel_valid_i,
    input  logic [$clog2(NUM_TASKS)-1:0]  rel_task_i,
    input  logic                          done_valid_i,
    input  logic [$clog2(NUM_CORES)-1:0]  done_core_i,
    output logic                          tick_o,
    output logic                          cmd_valid_o,
    output logic [1:0]                    cmd_op_o,
    output logic [$clog2(NUM_CORES)-1:0]  cmd_core_o,
    output logic [$clog2(NUM_TASKS)-1:0]  cmd_task_o,
    output logic [NUM_CORES-1:0]          core_busy_o,
    output logic                          err_o
);
    localparam int TW  = $clog2(NUM_TASKS);
    localparam int CW  = $clog2(NUM_CORES);
    localparam int QCW = $clog2(NUM_TASKS + 1);
    localparam logic [CW-1:0] LAST_CORE = CW'(NUM_CORES - 1);

    typedef struct packed {
        phase_e                       phase;
        logic [CW-1:0]                idx;
        logic [QCW-1:0]               elig;
        logic [NUM_CORES-1:0]         busy;
        logic [NUM_CORES-1:0][TW-1:0] task_id;
        logic                         tick;
        logic                         cmd_valid;
        op_e                          cmd_op;
        logic [CW-1:0]                cmd_core;
        logic [TW-1:0]                cmd_task;
        logic                         err;
    } disp_t;

    disp_t st_q, st_d;

    logic           tick_w;
    logic           rq_push0, rq_pop, rq_drop;
    logic [TW-1:0]  rq_data0, rq_head;
    logic [QCW-1:0] rq_count;
    logic           pq_push, pq_pop, pq_drop;
    logic [TW-1:0]  pq_data, pq_head;
    logic [QCW-1:0] pq_count;
    logic           done_hit;

    rrd_tick_gen #(.PERIOD(TICK_PERIOD)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick_w)
    );

    rrd_id_fifo #(.DEPTH(NUM_TASKS), .W(TW)) i_ready_q (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push0_i (rq_push0),
        .data0_i (rq_data0),
        .push1_i (rel_valid_i),
        .data1_i (rel_task_i),
        .pop_i   (rq_pop),
        .head_o  (rq_head),
        .count_o (rq_count),
        .drop_o  (rq_drop)
    );

    rrd_id_fifo #(.DEPTH(NUM_TASKS), .W(TW)) i_preempt_q (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push0_i (pq_push),
        .data0_i (pq_data),
        .push1_i (1'b0),
        .data1_i ('0),
        .pop_i   (pq_pop),
        .head_o  (pq_head),
        .count_o (pq_count),
        .drop_o  (pq_drop)
    );

    always_comb begin
        st_d           = st_q;
        st_d.tick      = tick_w;
        st_d.cmd_valid = 1'b0;
        st_d.cmd_op    = OP_NONE;
        st_d.cmd_core  = '0;
        st_d.cmd_task  = '0;
        rq_push0       = 1'b0;
        rq_data0       = '0;
        rq_pop         = 1'b0;
        pq_push        = 1'b0;
        pq_data        = '0;
        pq_pop         = 1'b0;

        // completion: only an occupied core can finish
        done_hit = done_valid_i && st_q.busy[done_core_i];
        if (done_hit) begin
            rq_push0                = 1'b1;
            rq_data0                = st_q.task_id[done_core_i];
            st_d.busy[done_core_i]  = 1'b0;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (tick_w) begin
                    st_d.phase = PH_PREEMPT;
                    st_d.idx   = '0;
                    st_d.elig  = pq_count;
                end
            end
            PH_PREEMPT: begin
                if (st_q.busy[st_q.idx] && !(done_hit && (done_core_i == st_q.idx))) begin
                    st_d.cmd_valid          = 1'b1;
                    st_d.cmd_op             = OP_PREEMPT;
                    st_d.cmd_core           = st_q.idx;
                    st_d.cmd_task           = st_q.task_id[st_q.idx];
                    pq_push                 = 1'b1;
                    pq_data                 = st_q.task_id[st_q.idx];
                    st_d.busy[st_q.idx]     = 1'b0;
                end
                if (st_q.idx == LAST_CORE) begin
                    st_d.phase = PH_ASSIGN;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_ASSIGN: begin
                if (!st_q.busy[st_q.idx]) begin
                    if (st_q.elig != '0) begin
                        pq_pop                  = 1'b1;
                        st_d.elig               = st_q.elig - 1'b1;
                        st_d.cmd_valid          = 1'b1;
                        st_d.cmd_op             = OP_RESUME;
                        st_d.cmd_core           = st_q.idx;
                        st_d.cmd_task           = pq_head;
                        st_d.busy[st_q.idx]     = 1'b1;
                        st_d.task_id[st_q.idx]  = pq_head;
                    end else if (rq_count != '0) begin
                        rq_pop                  = 1'b1;
                        st_d.cmd_valid          = 1'b1;
                        st_d.cmd_op             = OP_START;
                        st_d.cmd_core           = st_q.idx;
                        st_d.cmd_task           = rq_head;
                        st_d.busy[st_q.idx]     = 1'b1;
                        st_d.task_id[st_q.idx]  = rq_head;
                    end
                end
                if (st_q.idx == LAST_CORE) begin
                    st_d.phase = PH_IDLE;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        st_d.err = st_q.err | rq_drop | pq_drop;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o      = st_q.tick;
    assign cmd_valid_o = st_q.cmd_valid;
    assign cmd_op_o    = st_q.cmd_op;
    assign cmd_core_o  = st_q.cmd_core;
    assign cmd_task_o  = st_q.cmd_task;
    assign core_busy_o = st_q.busy;
    assign err_o       = st_q.err;
endmodule

// File: rtl/rrd_checker.sv
module rrd_checker #(
    parameter int NUM_CORES = 4
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          done_valid_i,
    input logic [$clog2(NUM_CORES)-1:0]  done_core_i,
    input logic                          tick_o,
    input logic                          cmd_valid_o,
    input logic [1:0]                    cmd_op_o,
    input logic [$clog2(NUM_CORES)-1:0]  cmd_core_o,
    input logic [NUM_CORES-1:0]          core_busy_o,
    input logic                          err_o
);
    localparam int SW  = $clog2(2 * NUM_CORES + 2) + 1;
    localparam int SAT = 2 * NUM_CORES + 1;

    logic [SW-1:0]        since_q;
    logic [NUM_CORES-1:0] busy_prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q     <= '0;
            busy_prev_q <= '0;
        end else begin
            busy_prev_q <= core_busy_o;
            if (tick_o)                     since_q <= SW'(1);
            else if (since_q == '0)         since_q <= '0;
            else if (int'(since_q) < SAT)   since_q <= since_q + 1'b1;
        end
    end

    AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R1

    AST_PREEMPT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && cmd_op_o == 2'd3) |-> (int'(since_q) == int'(cmd_core_o) + 1)); // R2

    AST_ASSIGN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && cmd_op_o != 2'd3) |-> (int'(since_q) == int'(cmd_core_o) + NUM_CORES + 1)); // R2

    AST_OP_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> (cmd_op_o != 2'd0)); // R3

    AST_PREEMPT_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && cmd_op_o == 2'd3) |-> (busy_prev_q[cmd_core_o] && !core_busy_o[cmd_core_o])); // R4

    AST_ASSIGN_OCCUPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2)) |-> (!busy_prev_q[cmd_core_o] && core_busy_o[cmd_core_o])); // R5

    AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_valid_i && core_busy_o[done_core_i]) |=> !core_busy_o[$past(done_core_i)]); // R8

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o); // R11
endmodule

bind preempt_rr_dispatcher rrd_checker #(.NUM_CORES(NUM_CORES)) i_rrd_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_valid_i (done_valid_i),
    .done_core_i  (done_core_i),
    .tick_o       (tick_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_core_o   (cmd_core_o),
    .core_busy_o  (core_busy_o),
    .err_o        (err_o)
);

// File: tb/test_preempt_rr_dispatcher.sv
module test_preempt_rr_dispatcher;
    localparam int N  = 4;
    localparam int T  = 8;
    localparam int P  = 16;
    localparam int TW = $clog2(T);
    localparam int CW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rel_valid = 1'b0;
    logic [TW-1:0] rel_task = '0;
    logic          done_valid = 1'b0;
    logic [CW-1:0] done_core = '0;
    logic          tick_o, cmd_valid_o, err_o;
    logic [1:0]    cmd_op_o;
    logic [CW-1:0] cmd_core_o;
    logic [TW-1:0] cmd_task_o;
    logic [N-1:0]  core_busy_o;

    always #5 clk = ~clk;

    preempt_rr_dispatcher #(.NUM_CORES(N), .NUM_TASKS(T), .TICK_PERIOD(P)) i_preempt_rr_dispatcher (
        .clk_i(clk), .rst_ni(rst_n),
        .rel_valid_i(rel_valid), .rel_task_i(rel_task),
        .done_valid_i(done_valid), .done_core_i(done_core),
        .tick_o(tick_o), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
        .cmd_core_o(cmd_core_o), .cmd_task_o(cmd_task_o),
        .core_busy_o(core_busy_o), .err_o(err_o)
    );

    int vectors = 0;
    int miscompares = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    // behavioural reference
    int m_rq[$];
    int m_pq[$];
    bit m_busy[N];
    int m_task[N];
    int m_cnt, m_phase, m_idx, m_elig;
    int e_tick, e_valid, e_op, e_core, e_task, e_err;

    always @(posedge clk) begin : ref_model
        int n_rq;
        int pushes;
        int dc;
        int dtask;
        int id;
        bit tk;
        bit dh;
        bit bs[N];
        if (!rst_n) begin
            m_rq.delete(); m_pq.delete();
            for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_task[i] = 0; end
            m_cnt = 0; m_phase = 0; m_idx = 0; m_elig = 0;
            e_tick = 0; e_valid = 0; e_op = 0; e_core = 0; e_task = 0; e_err = 0;
        end else begin
            n_rq = m_rq.size();
            pushes = 0;
            for (int i = 0; i < N; i++) bs[i] = m_busy[i];
            tk = (m_cnt == P - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            e_tick = tk; e_valid = 0; e_op = 0; e_core = 0; e_task = 0;
            dc = int'(done_core);
            dh = done_valid && bs[dc];
            dtask = m_task[dc];
            if (dh) m_busy[dc] = 0;
            if (m_phase == 0) begin
                if (tk) begin m_phase = 1; m_idx = 0; m_elig = m_pq.size(); end
            end else begin
                if (m_phase == 1) begin
                    if (bs[m_idx] && !(dh && dc == m_idx)) begin
                        e_valid = 1; e_op = 3; e_core = m_idx; e_task = m_task[m_idx];
                        if (m_pq.size() < T) m_pq.push_back(m_task[m_idx]); else e_err = 1;
                        m_busy[m_idx] = 0;
                    end
                end else if (!bs[m_idx]) begin
                    if (m_elig > 0) begin
                        id = m_pq.pop_front(); m_elig--;
                        e_valid = 1; e_op = 2; e_core = m_idx; e_task = id;
                        m_busy[m_idx] = 1; m_task[m_idx] = id;
                    end else if (n_rq > 0) begin
                        id = m_rq.pop_front();
                        e_valid = 1; e_op = 1; e_core = m_idx; e_task = id;
                        m_busy[m_idx] = 1; m_task[m_idx] = id;
                    end
                end
                if (m_idx == N - 1) begin m_idx = 0; m_phase = (m_phase == 1) ? 2 : 0; end
                else m_idx++;
            end
            // done enters before release (R10)
            if (dh) begin
                if (n_rq + pushes < T) begin m_rq.push_back(dtask); pushes++; end else e_err = 1;
            end
            if (rel_valid) begin
                if (n_rq + pushes < T) begin m_rq.push_back(int'(rel_task)); pushes++; end else e_err = 1;
            end
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            3: return "R4";
            2: return "R5 R7";
            1: return "R6";
            default: return "R2 R3";
        endcase
    endfunction

    always @(negedge clk) begin
        if (chk_on) begin
            logic [N-1:0] eb;
            for (int i = 0; i < N; i++) eb[i] = m_busy[i];
            cmp("R1", "tick", int'(tick_o), e_tick);
            cmp(op_tag(e_op), "cmd_valid", int'(cmd_valid_o), e_valid);
            cmp(op_tag(e_op), "cmd_op", int'(cmd_op_o), e_op);
            cmp(op_tag(e_op), "cmd_core", int'(cmd_core_o), e_core);
            cmp(op_tag(e_op), "cmd_task", int'(cmd_task_o), e_task);
            cmp("R8 R9", "core_busy", int'(core_busy_o), int'(eb));
            cmp("R11", "err", int'(err_o), e_err);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rel_valid = 1'b0; done_valid = 1'b0;
        end
    endtask

    task automatic wait_tick();
        forever begin
            @(negedge clk);
            rel_valid = 1'b0; done_valid = 1'b0;
            if (tick_o) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        cmp("R12", "cmd_valid", int'(cmd_valid_o), 0);
        cmp("R12", "core_busy", int'(core_busy_o), 0);
        cmp("R12", "err", int'(err_o), 0);
        cmp("R12", "tick", int'(tick_o), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R10: releases fill the ready queue in order
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rel_valid = 1'b1; rel_task = TW'(i);
        end
        idle(1);
        // R8: done on a free core is ignored
        done_valid = 1'b1; done_core = CW'(2);
        idle(1);
        // R1 R6: first pass starts four fresh jobs
        wait_tick();
        idle(9);
        done_valid = 1'b1; done_core = CW'(1);        // R8
        @(negedge clk);
        done_valid = 1'b1; done_core = CW'(3);        // R10: with release, same cycle
        rel_valid = 1'b1; rel_task = TW'(6);
        // R4 R7: second pass preempts, nothing eligible to resume yet
        wait_tick();
        // R5: third pass resumes the oldest preempted tasks
        wait_tick();
        // R9: done on core 1 exactly at its preemption visit
        wait_tick();
        @(negedge clk);
        done_valid = 1'b1; done_core = CW'(1);
        idle(1);
        idle(3 * P);
        // R11: overflow the ready queue with releases
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            done_valid = 1'b0;
            rel_valid = 1'b1; rel_task = TW'(7);
        end
        idle(3);
        cmp("R11", "err after overflow", int'(err_o), 1);
        idle(2 * P);
        cmp("R11", "err still set", int'(err_o), 1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule